// File: doc/BRIEF.md
# Program Status Word Access Unit

This block keeps the processor status word that an instruction pipeline reads and rewrites. The word is stored as two registers. One holds the condition flags: the top five flag bits and the four per-byte greater-or-equal bits. The other holds every remaining bit, including the interrupt masks and the mode field. A read combines the two registers and hides the reserved positions behind a fixed mask. A read is combinational, so the pipeline sees the current word in the same cycle.

A write takes a 32-bit operand, either from a register port or from an immediate port, together with a four-bit lane mask. Each byte lane whose mask bit is set takes the operand's byte, and each other lane keeps its stored byte. The merged word is then split back into the flag register and the control register on the next rising clock edge.

A separate control input can make fast interrupts non-maskable. While that input is high, a write cannot set the fast-interrupt mask bit, but a write can still clear it. A synchronous reset loads a privileged mode with both interrupt masks set.

Top module: `psw_access_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the stored word becomes 0x000001D3: mode 0x13, bits 8, 7 and 6 set, all flags clear. After reset, `rd_word` reads 0x000001D3, `flag_part` reads 0 and `ctrl_part` reads 0x000001D3.
- R2: `rd_word` always equals (`flag_part` | `ctrl_part`) & 0xF8FF03DF. Reserved bits that a write stores never show on `rd_word`.
- R3: On a write, each byte lane whose `wr_lanes` bit is 1 takes the operand's byte. Each lane whose bit is 0 keeps its stored byte.
- R4: `wr_lanes` bit 3 controls bits 31:24, bit 2 controls bits 23:16, bit 1 controls bits 15:8 and bit 0 controls bits 7:0.
- R5: After a write, `flag_part` holds the merged word's bits under 0xF80F0000 (bits 31:27 and 19:16), with every other bit 0. `ctrl_part` holds the remaining bits, with bits 31:27 and 19:16 at 0.
- R6: When `wr_sel_imm` is 1 the operand is `wr_imm`; when it is 0 the operand is `wr_reg`. Both sources go through the same merge.
- R7: While `fiq_nonmask` is 1, a write leaves bit 6 at 0 if it was 0. A write may still change bit 6 from 1 to 0. While `fiq_nonmask` is 0, bit 6 follows the merge like any other bit.
- R8: While `wr_en` is 0, neither `flag_part` nor `ctrl_part` changes.
- R9: A write is visible on `rd_word` only after the rising edge at which `wr_en` is sampled high. Before that edge, `rd_word` still shows the old word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_sel_imm | input | 1 | Operand source: 1 selects the immediate, 0 selects the register |
| wr_reg | input | 32 | Register operand |
| wr_imm | input | 32 | Immediate operand |
| wr_lanes | input | 4 | Byte-lane write enables |
| fiq_nonmask | input | 1 | Fast interrupts non-maskable; blocks setting bit 6 |
| rd_word | output | 32 | Masked, merged status word |
| flag_part | output | 32 | Stored condition-flag register |
| ctrl_part | output | 32 | Stored control register |

## Verification
The bench builds the unit with its default parameters: a 32-bit word, four byte lanes, read mask 0xF8FF03DF, flag mask 0xF80F0000 and the guarded bit at position 6. With these values, each single-lane write lands on a known field, so the lane order can be checked. An all-ones write puts the reserved positions behind the read mask and shows them there. With the guarded bit in lane 0, writes that touch the fast-interrupt mask show the protection with the input high and with it low.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int unsigned PSW_W = 32;
  localparam logic [PSW_W-1:0] PSW_READ_MASK = 32'hF8FF_03DF;
  localparam logic [PSW_W-1:0] PSW_FLAG_MASK = 32'hF80F_0000;
  localparam logic [PSW_W-1:0] PSW_RESET     = 32'h0000_01D3;
  localparam int unsigned PSW_FIQ_BIT = 6;
endpackage

// File: rtl/psw_lane_merge.sv
module psw_lane_merge #(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned LANES = WIDTH / 8
) (
  input  logic [WIDTH-1:0] cur_word,
  input  logic [WIDTH-1:0] new_word,
  input  logic [LANES-1:0] lane_en,
  output logic [WIDTH-1:0] merged
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[g*8 +: 8] = lane_en[g] ? new_word[g*8 +: 8] : cur_word[g*8 +: 8];
  end
endmodule

// File: rtl/psw_fiq_guard.sv
module psw_fiq_guard #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned GUARD_BIT = 6
) (
  input  logic [WIDTH-1:0] cur_word,
  input  logic [WIDTH-1:0] cand_word,
  input  logic             nonmask,
  output logic [WIDTH-1:0] out_word
);
  always_comb begin
    out_word = cand_word;
    if (nonmask && !cur_word[GUARD_BIT]) out_word[GUARD_BIT] = 1'b0;
  end
endmodule

// File: rtl/psw_split.sv
module psw_split #(
  parameter int unsigned WIDTH = 32,
  parameter logic [WIDTH-1:0] FLAG_MASK = '0
) (
  input  logic [WIDTH-1:0] word,
  output logic [WIDTH-1:0] flag_bits,
  output logic [WIDTH-1:0] ctrl_bits
);
  assign flag_bits = word & FLAG_MASK;
  assign ctrl_bits = word & ~FLAG_MASK;
endmodule

// File: rtl/psw_access_unit.sv
module psw_access_unit
  import psw_pkg::*;
#(
  parameter int unsigned WIDTH = PSW_W,
  parameter logic [WIDTH-1:0] READ_MASK = PSW_READ_MASK,
  parameter logic [WIDTH-1:0] FLAG_MASK = PSW_FLAG_MASK,
  parameter logic [WIDTH-1:0] RESET_WORD = PSW_RESET,
  parameter int unsigned FIQ_BIT = PSW_FIQ_BIT,
  localparam int unsigned LANES = WIDTH / 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_sel_imm,
  input  logic [WIDTH-1:0] wr_reg,
  input  logic [WIDTH-1:0] wr_imm,
  input  logic [LANES-1:0] wr_lanes,
  input  logic             fiq_nonmask,
  output logic [WIDTH-1:0] rd_word,
  output logic [WIDTH-1:0] flag_part,
  output logic [WIDTH-1:0] ctrl_part
);
  logic [WIDTH-1:0] flag_q, ctrl_q;
  logic [WIDTH-1:0] stored, operand, merged, guarded;
  logic [WIDTH-1:0] flag_nxt, ctrl_nxt;
  logic [WIDTH-1:0] rst_flag, rst_ctrl;

  assign stored  = flag_q | ctrl_q;
  assign operand = wr_sel_imm ? wr_imm : wr_reg;

  psw_lane_merge #(.WIDTH(WIDTH)) i_merge (
    .cur_word(stored), .new_word(operand), .lane_en(wr_lanes), .merged(merged)
  );

  psw_fiq_guard #(.WIDTH(WIDTH), .GUARD_BIT(FIQ_BIT)) i_guard (
    .cur_word(stored), .cand_word(merged), .nonmask(fiq_nonmask), .out_word(guarded)
  );

  psw_split #(.WIDTH(WIDTH), .FLAG_MASK(FLAG_MASK)) i_split (
    .word(guarded), .flag_bits(flag_nxt), .ctrl_bits(ctrl_nxt)
  );

  psw_split #(.WIDTH(WIDTH), .FLAG_MASK(FLAG_MASK)) i_rst_split (
    .word(RESET_WORD), .flag_bits(rst_flag), .ctrl_bits(rst_ctrl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= rst_flag;
      ctrl_q <= rst_ctrl;
    end else if (wr_en) begin
      flag_q <= flag_nxt;
      ctrl_q <= ctrl_nxt;
    end
  end

  assign rd_word   = stored & READ_MASK;
  assign flag_part = flag_q;
  assign ctrl_part = ctrl_q;

  // R8
  no_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(flag_q) && $stable(ctrl_q)));

  // R5
  split_disjoint_chk: assert property (@(posedge clk) disable iff (rst)
    ((flag_q & ~FLAG_MASK) == '0) && ((ctrl_q & FLAG_MASK) == '0));

  // R7
  fiq_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && fiq_nonmask && !stored[FIQ_BIT]) |=> !stored[FIQ_BIT]);

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    localparam logic [7:0] CMP = (FIQ_BIT / 8 == g) ? ~(8'h01 << (FIQ_BIT % 8)) : 8'hFF;
    // R3
    lane_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !wr_lanes[g]) |=> $stable(stored[g*8 +: 8]));
    // R6
    lane_load_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_lanes[g]) |=>
        ((stored[g*8 +: 8] & CMP) == ($past(operand[g*8 +: 8]) & CMP)));
  end
endmodule

// File: tb/test_psw_access_unit.sv
`timescale 1ns/1ps
module test_psw_access_unit;
  localparam logic [31:0] RMASK = 32'hF8FF_03DF;
  localparam logic [31:0] FMASK = 32'hF80F_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, wr_sel_imm = 1'b0, fiq_nonmask = 1'b0;
  logic [31:0] wr_reg = '0, wr_imm = '0;
  logic [3:0] wr_lanes = '0;
  logic [31:0] rd_word, flag_part, ctrl_part;

  int checks = 0;
  int fails = 0;
  logic [31:0] model = '0;

  always #5 clk = ~clk;

  psw_access_unit i_psw_access_unit (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel_imm(wr_sel_imm),
    .wr_reg(wr_reg), .wr_imm(wr_imm), .wr_lanes(wr_lanes),
    .fiq_nonmask(fiq_nonmask), .rd_word(rd_word),
    .flag_part(flag_part), .ctrl_part(ctrl_part)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, rd_word, model & RMASK);
    chk(req, flag_part, model & FMASK);
    chk(req, ctrl_part, model & ~FMASK);
  endtask

  task automatic do_write(input logic [31:0] data, input logic use_imm,
                          input logic [3:0] lanes, input logic nm, input logic en);
    logic [31:0] nxt;
    @(negedge clk);
    wr_en = en; wr_sel_imm = use_imm; wr_lanes = lanes; fiq_nonmask = nm;
    wr_reg = use_imm ? ~data : data;
    wr_imm = use_imm ? data : ~data;
    #1;
    chk("R9", rd_word, model & RMASK);
    nxt = model;
    for (int i = 0; i < 4; i++) if (lanes[i]) nxt[i*8 +: 8] = data[i*8 +: 8];
    if (nm && !model[6]) nxt[6] = 1'b0;
    if (en) model = nxt;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", rd_word, 32'h0000_01D3);
    chk("R1", flag_part, 32'h0);
    chk("R1", ctrl_part, 32'h0000_01D3);
    model = 32'h0000_01D3;
  endtask

  task automatic t_full_write;
    do_write(32'hA5C3_5A96, 1'b0, 4'hF, 1'b0, 1'b1);
    chk_all("R5");
    chk("R2", rd_word, 32'hA0C3_0296);
  endtask

  task automatic t_lanes;
    for (int i = 0; i < 4; i++) begin
      do_write(32'h0, 1'b0, 4'hF, 1'b0, 1'b1);
      do_write(32'hFFFF_FFFF, 1'b0, 4'b0001 << i, 1'b0, 1'b1);
      chk("R4", flag_part | ctrl_part, 32'hFF << (8 * i));
      chk_all("R3");
    end
  endtask

  task automatic t_imm;
    do_write(32'h1234_5678, 1'b1, 4'hF, 1'b0, 1'b1);
    chk("R6", flag_part | ctrl_part, 32'h1234_5678);
    do_write(32'h8765_4321, 1'b0, 4'b0110, 1'b0, 1'b1);
    chk("R6", flag_part | ctrl_part, 32'h1265_4378);
    chk_all("R6");
  endtask

  task automatic t_reserved;
    do_write(32'hFFFF_FFFF, 1'b1, 4'hF, 1'b0, 1'b1);
    chk("R2", rd_word, 32'hF8FF_03DF);
    chk("R5", flag_part, 32'hF80F_0000);
    chk("R5", ctrl_part, 32'h07F0_FFFF);
  endtask

  task automatic t_hold;
    do_write(32'h0000_0000, 1'b0, 4'hF, 1'b1, 1'b0);
    chk("R8", flag_part, 32'hF80F_0000);
    chk("R8", ctrl_part, 32'h07F0_FFFF);
  endtask

  task automatic t_fiq;
    do_write(32'h0000_0000, 1'b0, 4'hF, 1'b0, 1'b1);
    do_write(32'h0000_00C0, 1'b0, 4'b0001, 1'b1, 1'b1);
    chk("R7", rd_word, 32'h0000_0080);
    do_write(32'h0000_00C0, 1'b0, 4'b0001, 1'b0, 1'b1);
    chk("R7", rd_word, 32'h0000_00C0);
    do_write(32'h0000_0040, 1'b0, 4'b0001, 1'b1, 1'b1);
    chk("R7", rd_word, 32'h0000_0040);
    do_write(32'h0000_0000, 1'b0, 4'b0001, 1'b1, 1'b1);
    chk("R7", rd_word, 32'h0000_0000);
    chk_all("R7");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog got timeout exp completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_full_write();
    t_lanes();
    t_imm();
    t_reserved();
    t_hold();
    t_fiq();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule